// File: doc/BRIEF.md
# Framed Word Serializer with Link Power Sequencing

This block turns a stream of parallel words into a single serial bit stream. It runs on a bit clock that is twelve times the word rate. It watches a slower word clock and takes one data word on each rising edge of that clock. Each word goes out as a twelve-bit frame. The data bits come first, least significant bit first. Two boundary bits follow them, and the receiver uses these to find where each word starts. The first boundary bit is the inverse of the top data bit, and the second is the inverse of the first. So every frame has at least two level changes.

The block also controls the link power state. When the enable input is low, the link is powered down and a one-cycle power-down indication goes to the far end. After the enable rises, the link counts a fixed number of word clock edges for synchronisation before it accepts data. If the receiver reports a word boundary error while data is running, the link enters a timed recovery hold, then runs the synchronisation count again. The output driver is enabled only while data is running. At all other times the line sits at a fixed idle level.

Top module: `ser_link_top`

## Requirements
- R1: A word is captured on the bit-clock edge where the word clock is first seen high. The frame then leaves on `sdo`, one bit per bit clock, starting right after that edge. The order is data bit 0 through data bit DATA_W-1, then boundary bit A, then boundary bit B.
- R2: Boundary bit A equals the inverse of data bit DATA_W-1. Boundary bit B equals the inverse of boundary bit A.
- R3: After reset the link is powered down: `link_state`=0, `sdo_oe`=0, `sdo`=0 and `far_pd`=0.
- R4: When `link_en` is high, a powered-down link enters synchronising one bit clock later. It stays there for SYNC_WORDS word clock rising edges and moves to running on the last of them. Words offered during that window are never sent. The first word sent is the one captured on the next rising edge.
- R5: `sdo_oe` is high only while running. Whenever `sdo_oe` is low, `sdo` holds the idle level 0.
- R6: A high `link_err` while running moves the link to recovery on the next bit clock, and the output is disabled. The link stays in recovery for REC_WORDS word clock rising edges, then re-enters synchronising and runs the full count again.
- R7: `link_err` has no effect in the powered-down, synchronising and recovery states.
- R8: A low `link_en` moves the link to powered-down on the next bit clock from any state, even in the middle of a frame. `far_pd` is high for exactly one bit clock on that entry. It does not pulse while the link is already powered down.
- R9: `link_state` encodes 0 as powered-down, 1 as synchronising, 2 as running and 3 as recovery.
- R10: Changes on `din` between word clock rising edges do not change the frame already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve times the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk | input | 1 | Word clock, sampled on the bit clock |
| din | input | DATA_W | Parallel data word |
| link_en | input | 1 | High to power the link up; low to power it down |
| link_err | input | 1 | Word boundary error request from the receiver |
| sdo | output | 1 | Serial output bit |
| sdo_oe | output | 1 | Output drive enable |
| far_pd | output | 1 | One-cycle power-down indication to the far end |
| link_state | output | 2 | Link state code |

## Verification
The hardest case to reach is a recovery that restarts cleanly. The test needs a link that is running and sending frames, an error arriving, and the error input held high through the whole recovery hold. Then the full synchronisation count must run again before data flows. The bench builds the block with short counts. It steps the word clock one edge at a time and checks the state code after the edge just before each boundary and after the boundary edge itself. It then sends a frame whose bits it checks one by one. A separate scenario drops the enable in the middle of a frame. This checks that the line goes idle at once and that the far-end pulse lasts exactly one bit clock.

// File: rtl/ser_link_pkg.sv
package ser_link_pkg;
    typedef enum logic [1:0] {
        LS_OFF   = 2'd0,
        LS_SYNC  = 2'd1,
        LS_RUN   = 2'd2,
        LS_RECOV = 2'd3
    } link_st_e;

    localparam logic IDLE_LVL = 1'b0;
endpackage

// File: rtl/pclk_rise.sv
module pclk_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk,
    output logic rise
);
    logic pclk_d, pclk_q;

    always_comb begin
        pclk_d = pclk;
        rise   = pclk & ~pclk_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pclk_q <= 1'b0;
        else        pclk_q <= pclk_d;
    end
endmodule

// File: rtl/link_seq.sv
module link_seq
    import ser_link_pkg::*;
#(
    parameter int SYNC_WORDS = 11264,
    parameter int REC_WORDS  = 20
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     link_en,
    input  logic     link_err,
    input  logic     rise,
    output link_st_e state,
    output logic     far_pd
);
    localparam int MAX_W = (SYNC_WORDS > REC_WORDS) ? SYNC_WORDS : REC_WORDS;
    localparam int CNT_W = $clog2(MAX_W + 1);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_WORDS - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_WORDS - 1);

    typedef struct packed {
        link_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic             pd;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        seq_d.pd = 1'b0;
        if (!link_en) begin
            seq_d.st  = LS_OFF;
            seq_d.cnt = '0;
            seq_d.pd  = (seq_q.st != LS_OFF);
        end else begin
            unique case (seq_q.st)
                LS_OFF: begin
                    seq_d.st  = LS_SYNC;
                    seq_d.cnt = '0;
                end
                LS_SYNC: begin
                    if (rise) begin
                        if (seq_q.cnt == SYNC_LAST) begin
                            seq_d.st  = LS_RUN;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                LS_RUN: begin
                    if (link_err) begin
                        seq_d.st  = LS_RECOV;
                        seq_d.cnt = '0;
                    end
                end
                LS_RECOV: begin
                    if (rise) begin
                        if (seq_q.cnt == REC_LAST) begin
                            seq_d.st  = LS_SYNC;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                default: seq_d.st = LS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: LS_OFF, cnt: '0, pd: 1'b0};
        else        seq_q <= seq_d;
    end

    assign state  = seq_q.st;
    assign far_pd = seq_q.pd;

    // R8: power-down wins from any state
    p_pd_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> state == LS_OFF);

    // R6: boundary error while running leads to recovery
    p_err_recov_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_RUN && link_en && link_err) |=> state == LS_RECOV);

    // R4: synchronising only moves on a word clock edge or power-down
    p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_SYNC && link_en && !rise) |=> state == LS_SYNC);

    // R7: error input never leaves the recovery hold early
    p_recov_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_RECOV && link_en && !rise) |=> state == LS_RECOV);
endmodule

// File: rtl/frame_shift.sv
module frame_shift
    import ser_link_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              flush,
    input  logic [DATA_W-1:0] word,
    output logic              bit_o
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam logic [IDX_W-1:0] IDX_EMPTY = IDX_W'(FRAME_W);
    localparam logic [IDX_W-1:0] IDX_BA    = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] IDX_BB    = IDX_W'(DATA_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [IDX_W-1:0]   idx;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (flush) begin
            shf_d.sr  = '0;
            shf_d.idx = IDX_EMPTY;
        end else if (load) begin
            shf_d.sr  = {word[DATA_W-1], ~word[DATA_W-1], word};
            shf_d.idx = '0;
        end else if (shf_q.idx != IDX_EMPTY) begin
            shf_d.sr  = {1'b0, shf_q.sr[FRAME_W-1:1]};
            shf_d.idx = shf_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '{sr: '0, idx: IDX_EMPTY};
        else        shf_q <= shf_d;
    end

    assign bit_o = shf_q.sr[0];

    // R2: each boundary bit differs from the bit sent before it
    p_bound_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.idx == IDX_BA |-> shf_q.sr[0] != $past(shf_q.sr[0]));
    p_bound_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.idx == IDX_BB |-> shf_q.sr[0] != $past(shf_q.sr[0]));
endmodule

// File: rtl/ser_link_top.sv
module ser_link_top
    import ser_link_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int SYNC_WORDS = 11264,
    parameter int REC_WORDS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk,
    input  logic [DATA_W-1:0] din,
    input  logic              link_en,
    input  logic              link_err,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              far_pd,
    output logic [1:0]        link_state
);
    logic     rise;
    logic     ser_bit;
    link_st_e st;

    pclk_rise u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pclk  (pclk),
        .rise  (rise)
    );

    link_seq #(
        .SYNC_WORDS (SYNC_WORDS),
        .REC_WORDS  (REC_WORDS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .link_err (link_err),
        .rise     (rise),
        .state    (st),
        .far_pd   (far_pd)
    );

    frame_shift #(
        .DATA_W (DATA_W)
    ) u_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rise && st == LS_RUN),
        .flush (st != LS_RUN),
        .word  (din),
        .bit_o (ser_bit)
    );

    always_comb begin
        sdo_oe     = (st == LS_RUN);
        sdo        = sdo_oe ? ser_bit : IDLE_LVL;
        link_state = st;
    end

    // R8: far-end pulse only on entry into power-down
    p_far_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        far_pd |-> (link_state == LS_OFF && $past(link_state) != LS_OFF));

    // R5: line idle while the driver is off
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> sdo == IDLE_LVL);
endmodule

// File: tb/ser_link_top_test.sv
module ser_link_top_test;
    localparam int DW    = 10;
    localparam int SYNCN = 8;
    localparam int RECN  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pclk = 1'b0;
    logic [DW-1:0] din = '0;
    logic          link_en = 1'b0;
    logic          link_err = 1'b0;
    logic          sdo, sdo_oe, far_pd;
    logic [1:0]    link_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ser_link_top #(.DATA_W(DW), .SYNC_WORDS(SYNCN), .REC_WORDS(RECN)) uut (
        .clk(clk), .rst_n(rst_n), .pclk(pclk), .din(din),
        .link_en(link_en), .link_err(link_err),
        .sdo(sdo), .sdo_oe(sdo_oe), .far_pd(far_pd), .link_state(link_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one word clock period, 12 bit clocks, without checking the line
    task automatic word_cycle(input logic [DW-1:0] d);
        din  = d;
        pclk = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i == 5) pclk = 1'b0;
        end
    endtask

    // one word clock period, checking every bit of the frame
    task automatic send_word(input logic [DW-1:0] d, input string req);
        logic [11:0] exp;
        exp  = {d[DW-1], ~d[DW-1], d};
        din  = d;
        pclk = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(sdo === exp[i] && sdo_oe === 1'b1, req, {sdo_oe, sdo}, {1'b1, exp[i]});
            if (i == 3) din = ~d;          // R10: mid-frame change
            if (i == 5) pclk = 1'b0;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(link_state == 2'd0, "R3 state", link_state, 0);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R3 line", {sdo_oe, sdo}, 0);
        chk(far_pd == 1'b0, "R3 far_pd", far_pd, 0);
    endtask

    task automatic t_powerup;
        link_err = 1'b1;                   // R7: ignored while off
        repeat (3) @(negedge clk);
        chk(link_state == 2'd0, "R7 off ignores err", link_state, 0);
        link_err = 1'b0;
        link_en  = 1'b1;
        @(negedge clk);
        chk(link_state == 2'd1, "R4 enter sync", link_state, 1);
        for (int k = 0; k < SYNCN - 1; k++) begin
            link_err = (k == 2);           // R7: ignored while synchronising
            word_cycle(DW'(10'h3A5 + k));
            chk(sdo == 1'b0 && sdo_oe == 1'b0, "R5 idle in sync", {sdo_oe, sdo}, 0);
        end
        link_err = 1'b0;
        chk(link_state == 2'd1, "R4 still sync", link_state, 1);
        word_cycle(10'h155);
        chk(link_state == 2'd2, "R4 R9 running", link_state, 2);
        chk(sdo_oe == 1'b1 && sdo == 1'b0, "R4 no stale word", {sdo_oe, sdo}, 2);
    endtask

    task automatic t_frames;
        send_word(10'h2D3, "R1 frame a");
        send_word(10'h0F0, "R2 frame b");
        send_word(10'h3FF, "R2 frame c");
        send_word(10'h000, "R10 frame d");
    endtask

    task automatic t_recovery;
        link_err = 1'b1;
        @(negedge clk);
        chk(link_state == 2'd3, "R6 R9 recovery", link_state, 3);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R5 R6 line off", {sdo_oe, sdo}, 0);
        for (int k = 0; k < RECN - 1; k++) word_cycle(10'h1C7);
        chk(link_state == 2'd3, "R7 recovery hold", link_state, 3);
        word_cycle(10'h1C7);
        chk(link_state == 2'd1, "R6 back to sync", link_state, 1);
        link_err = 1'b0;
        for (int k = 0; k < SYNCN - 1; k++) word_cycle(10'h2AA);
        chk(link_state == 2'd1, "R6 full sync again", link_state, 1);
        word_cycle(10'h2AA);
        chk(link_state == 2'd2, "R6 running again", link_state, 2);
        send_word(10'h1B4, "R6 frame after restart");
    endtask

    task automatic t_powerdown;
        din  = 10'h26B;
        pclk = 1'b1;
        repeat (4) @(negedge clk);
        link_en = 1'b0;
        @(negedge clk);
        chk(link_state == 2'd0, "R8 off mid-frame", link_state, 0);
        chk(far_pd == 1'b1, "R8 pulse", far_pd, 1);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R8 line idle", {sdo_oe, sdo}, 0);
        pclk = 1'b0;
        @(negedge clk);
        chk(far_pd == 1'b0, "R8 pulse width", far_pd, 0);
        repeat (5) @(negedge clk);
        chk(far_pd == 1'b0 && link_state == 2'd0, "R8 no repeat", {far_pd, link_state}, 0);
        link_en = 1'b1;
        @(negedge clk);
        chk(link_state == 2'd1, "R4 sync after off", link_state, 1);
        link_en = 1'b0;
        @(negedge clk);
        chk(far_pd == 1'b1 && link_state == 2'd0, "R8 pulse from sync", {far_pd, link_state}, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_powerup();
        t_frames();
        t_recovery();
        t_powerdown();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule